// File: doc/BRIEF.md
# Bus I/O Wait-State Delay Generator

This block stalls a requester after each port I/O access for a span that depends on the access width and direction. It models the wait-state cost of an expansion-bus transfer. A byte access costs eight and a half bus clocks, which stands for four wait states. A word access costs five and a half bus clocks, which stands for one wait state. A doubleword access is charged as two word transfers, eleven bus clocks in total. A write costs three quarters of the read cost for the same width, rounded down.

The block is clocked at twice the bus clock, so one cycle is one half bus clock and every default cost is a whole number of cycles (byte 17, word 11, doubleword 22). Each width has its own signed override input, given in half-bus-clock units. A negative override keeps the built-in cost. A zero or positive override replaces it. While the bypass input is high, an access costs nothing.

The controller is a three-state machine:
- **IDLE** waits for a strobe and moves to **COUNT** for a non-zero cost, or straight to **FINISH** for a zero cost.
- **COUNT** drives the stall output and counts down once per cycle. It moves to **FINISH** when the last cycle of the cost has elapsed.
- **FINISH** raises the done pulse for one cycle and returns to **IDLE**.

Top module: `isa_iowait_gen`

## Requirements
- R1: After reset, `stall` and `done` are low and the block is idle.
- R2: A byte read (`acc_size` = 2'b00, `acc_wr` = 0) with a negative byte override stalls for 17 cycles.
- R3: A word read (`acc_size` = 2'b01) with a negative word override stalls for 11 cycles.
- R4: A doubleword read (`acc_size` = 2'b10, with 2'b11 treated the same) with a negative doubleword override stalls for 22 cycles.
- R5: A write (`acc_wr` = 1) stalls for floor(3/4 of the read cost) of the same width: 12 cycles for a byte, 8 for a word and 16 for a doubleword.
- R6: A zero or positive override for the accessed width replaces the built-in read cost, in half-bus-clock cycles, before the write scaling is applied. A negative override leaves the built-in cost in place.
- R7: When the cost is zero, or when `bypass` is high with the strobe, `stall` stays low and `done` pulses in the cycle after the strobe.
- R8: `stall` rises in the cycle after an accepted strobe and stays high for exactly the cost in cycles. `done` pulses for one cycle right after the last stall cycle. `stall` and `done` are never high together.
- R9: A strobe that arrives while `stall` or `done` is high is ignored: it neither changes the current stall length nor starts a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bus clock (one half bus clock per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | One-cycle access strobe |
| acc_size | input | 2 | Access width: 00 byte, 01 word, 10/11 doubleword |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| bypass | input | 1 | When high with the strobe, no delay is charged |
| ovr_byte | input | OVR_W | Signed byte-access cost override, in half-clock units (negative selects the default) |
| ovr_word | input | OVR_W | Signed word-access cost override, in half-clock units (negative selects the default) |
| ovr_dword | input | OVR_W | Signed doubleword-access cost override, in half-clock units (negative selects the default) |
| stall | output | 1 | High while the requester must wait |
| done | output | 1 | One-cycle pulse when the access delay has ended |

## Verification
The assertions check several rules on every cycle:
- `stall` and `done` are never high together, and `done` lasts only one cycle.
- A strobe arriving while the block is busy never cuts the stall short.
- A zero-cost access goes straight to `done`, and a non-zero one starts `stall` in the next cycle.

The exact length of each stall can only be shown by the bench's scenarios. These cover the per-width defaults, the write scaling with its rounding, override selection and the bypass condition. They are compared against a behavioural reference model on every clock.

// File: rtl/iow_pkg.sv
package iow_pkg;

    typedef enum logic [1:0] {
        IOW_IDLE   = 2'd0,
        IOW_COUNT  = 2'd1,
        IOW_FINISH = 2'd2
    } iow_state_e;

    // access width encodings
    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_WORD  = 2'b01;
    localparam logic [1:0] SZ_DWORD = 2'b10;
    localparam logic [1:0] SZ_DWALT = 2'b11;

    // built-in read costs in half bus clocks
    localparam int HALF_BYTE  = 17;  // 8.5 bus clocks
    localparam int HALF_WORD  = 11;  // 5.5 bus clocks
    localparam int HALF_DWORD = 22;  // two word transfers

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/iow_base_sel.sv
module iow_base_sel
    import iow_pkg::*;
#(
    parameter int OVR_W     = 8,
    parameter int DEF_BYTE  = HALF_BYTE,
    parameter int DEF_WORD  = HALF_WORD,
    parameter int DEF_DWORD = HALF_DWORD
) (
    input  logic [1:0]       size_i,
    input  logic [OVR_W-1:0] ovr_byte_i,
    input  logic [OVR_W-1:0] ovr_word_i,
    input  logic [OVR_W-1:0] ovr_dword_i,
    output logic [OVR_W-1:0] base_o
);

    logic [NUM_LANES-1:0][OVR_W-1:0] ovr_vec;
    logic [NUM_LANES-1:0][OVR_W-1:0] def_vec;
    logic [NUM_LANES-1:0][OVR_W-1:0] lane_val;

    assign ovr_vec[0] = ovr_byte_i;
    assign ovr_vec[1] = ovr_word_i;
    assign ovr_vec[2] = ovr_dword_i;

    assign def_vec[0] = OVR_W'(DEF_BYTE);
    assign def_vec[1] = OVR_W'(DEF_WORD);
    assign def_vec[2] = OVR_W'(DEF_DWORD);

    // each lane: a negative override (sign bit set) falls back to the default
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_val[g] = ovr_vec[g][OVR_W-1] ? def_vec[g] : ovr_vec[g];
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE:  base_o = lane_val[0];
            SZ_WORD:  base_o = lane_val[1];
            SZ_DWORD: base_o = lane_val[2];
            SZ_DWALT: base_o = lane_val[2];
            default:  base_o = lane_val[2];
        endcase
    end

endmodule

// File: rtl/iow_wr_scale.sv
module iow_wr_scale #(
    parameter int W = 8
) (
    input  logic [W-1:0] base_i,
    input  logic         is_wr_i,
    output logic [W-1:0] cost_o
);

    localparam int EXT_W = W + 2;

    logic [EXT_W-1:0] triple;

    // 3*base computed as base + 2*base, then divided by four (floor)
    assign triple = {2'b00, base_i} + {1'b0, base_i, 1'b0};

    always_comb begin
        if (is_wr_i) begin
            cost_o = triple[EXT_W-1:2];
        end else begin
            cost_o = base_i;
        end
    end

endmodule

// File: rtl/iow_fsm.sv
module iow_fsm
    import iow_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             stall_o,
    output logic             done_o
);

    iow_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             zero_cost;

    assign zero_cost = bypass_i || (load_i == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IOW_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IOW_IDLE: begin
                if (stb_i) begin
                    cnt_d   = load_i;
                    state_d = zero_cost ? IOW_FINISH : IOW_COUNT;
                end
            end
            IOW_COUNT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    state_d = IOW_FINISH;
                end
            end
            IOW_FINISH: begin
                state_d = IOW_IDLE;
            end
            default: begin
                state_d = IOW_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        stall_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            IOW_IDLE:   ;
            IOW_COUNT:  stall_o = 1'b1;
            IOW_FINISH: done_o  = 1'b1;
            default:    ;
        endcase
    end

    // R8
    stall_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && done_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IOW_IDLE && stb_i && !zero_cost) |=> stall_o);

    // R7
    zero_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IOW_IDLE && stb_i && zero_cost) |=> (done_o && !stall_o));

    // R9
    busy_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && stb_i && cnt_q > CNT_W'(1)) |=> stall_o);

    // R8
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (cnt_q != '0));

endmodule

// File: rtl/isa_iowait_gen.sv
module isa_iowait_gen
    import iow_pkg::*;
#(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_stb,
    input  logic [1:0]       acc_size,
    input  logic             acc_wr,
    input  logic             bypass,
    input  logic [OVR_W-1:0] ovr_byte,
    input  logic [OVR_W-1:0] ovr_word,
    input  logic [OVR_W-1:0] ovr_dword,
    output logic             stall,
    output logic             done
);

    localparam int CNT_W = OVR_W;

    logic [OVR_W-1:0] base_cost;
    logic [CNT_W-1:0] final_cost;

    iow_base_sel #(
        .OVR_W (OVR_W)
    ) base_sel_i (
        .size_i      (acc_size),
        .ovr_byte_i  (ovr_byte),
        .ovr_word_i  (ovr_word),
        .ovr_dword_i (ovr_dword),
        .base_o      (base_cost)
    );

    iow_wr_scale #(
        .W (CNT_W)
    ) wr_scale_i (
        .base_i  (base_cost),
        .is_wr_i (acc_wr),
        .cost_o  (final_cost)
    );

    iow_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (acc_stb),
        .bypass_i (bypass),
        .load_i   (final_cost),
        .stall_o  (stall),
        .done_o   (done)
    );

    // R5
    wr_cost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> (final_cost <= base_cost));

endmodule

// File: tb/isa_iowait_gen_tb_top.sv
module isa_iowait_gen_tb_top;

    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_stb = 1'b0;
    logic [1:0]       acc_size = 2'b00;
    logic             acc_wr = 1'b0;
    logic             bypass = 1'b0;
    logic signed [7:0] ovr_byte = -8'sd1;
    logic signed [7:0] ovr_word = -8'sd1;
    logic signed [7:0] ovr_dword = -8'sd1;
    logic             stall;
    logic             done;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    isa_iowait_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_stb   (acc_stb),
        .acc_size  (acc_size),
        .acc_wr    (acc_wr),
        .bypass    (bypass),
        .ovr_byte  (ovr_byte),
        .ovr_word  (ovr_word),
        .ovr_dword (ovr_dword),
        .stall     (stall),
        .done      (done)
    );

    // behavioural reference model: phase 0 idle, 1 stalling, 2 done
    int m_phase = 0;
    int m_left = 0;

    function automatic int ref_cost(input logic [1:0] sz, input logic wr, input logic byp,
                                    input int ob, input int ow, input int od);
        int b;
        if (byp) return 0;
        if (sz == 2'b00)      b = (ob < 0) ? 17 : ob;
        else if (sz == 2'b01) b = (ow < 0) ? 11 : ow;
        else                  b = (od < 0) ? 22 : od;
        if (wr) b = (b * 3) / 4;
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0;
            m_left  <= 0;
        end else if (m_phase == 0) begin
            if (acc_stb) begin
                int c;
                c = ref_cost(acc_size, acc_wr, bypass, int'(ovr_byte), int'(ovr_word), int'(ovr_dword));
                m_left  <= c;
                m_phase <= (c == 0) ? 2 : 1;
            end
        end else if (m_phase == 1) begin
            m_left <= m_left - 1;
            if (m_left == 1) m_phase <= 2;
        end else begin
            m_phase <= 0;
        end
    end

    // per-cycle comparison against the model (R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (stall !== (m_phase == 1) || done !== (m_phase == 2)) begin
                n_fail++;
                $display("FAIL R8 model compare t=%0t stall=%b done=%b expected stall=%b done=%b",
                         $time, stall, done, (m_phase == 1), (m_phase == 2));
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // one access; returns measured stall length; optional stray strobe during stall
    task automatic run_access(input logic [1:0] sz, input logic wr, input logic byp,
                              input bit stray, output int len);
        int guard;
        len = 0;
        guard = 0;
        @(posedge clk); #2;
        acc_stb = 1'b1; acc_size = sz; acc_wr = wr; bypass = byp;
        @(posedge clk); #2;
        acc_stb = 1'b0;
        forever begin
            @(negedge clk);
            if (stall) len++;
            if (stray && len == 3) begin
                #1 acc_stb = 1'b1; acc_size = 2'b01;
                @(posedge clk); #2 acc_stb = 1'b0;
                @(negedge clk);
                if (stall) len++;
            end
            if (done) break;
            guard++;
            if (guard > 300) break;
        end
        bypass = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int len;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 stall after reset", int'(stall), 0);
        check_eq("R1 done after reset", int'(done), 0);
        #2 rst_n = 1'b1;

        run_access(2'b00, 1'b0, 1'b0, 1'b0, len); check_eq("R2 byte read", len, 17);
        run_access(2'b01, 1'b0, 1'b0, 1'b0, len); check_eq("R3 word read", len, 11);
        run_access(2'b10, 1'b0, 1'b0, 1'b0, len); check_eq("R4 dword read", len, 22);
        run_access(2'b11, 1'b0, 1'b0, 1'b0, len); check_eq("R4 dword alt code", len, 22);
        run_access(2'b00, 1'b1, 1'b0, 1'b0, len); check_eq("R5 byte write", len, 12);
        run_access(2'b01, 1'b1, 1'b0, 1'b0, len); check_eq("R5 word write", len, 8);
        run_access(2'b10, 1'b1, 1'b0, 1'b0, len); check_eq("R5 dword write", len, 16);

        ovr_word = 8'sd4;
        run_access(2'b01, 1'b0, 1'b0, 1'b0, len); check_eq("R6 word override read", len, 4);
        run_access(2'b01, 1'b1, 1'b0, 1'b0, len); check_eq("R6 word override write", len, 3);
        run_access(2'b00, 1'b0, 1'b0, 1'b0, len); check_eq("R6 byte unaffected", len, 17);
        ovr_dword = 8'sd40;
        run_access(2'b10, 1'b1, 1'b0, 1'b0, len); check_eq("R6 dword override write", len, 30);
        ovr_dword = -8'sd5;
        run_access(2'b10, 1'b0, 1'b0, 1'b0, len); check_eq("R6 negative keeps default", len, 22);

        ovr_byte = 8'sd0;
        run_access(2'b00, 1'b0, 1'b0, 1'b0, len); check_eq("R7 zero override", len, 0);
        ovr_byte = 8'sd1;
        run_access(2'b00, 1'b1, 1'b0, 1'b0, len); check_eq("R7 write rounds to zero", len, 0);
        run_access(2'b00, 1'b0, 1'b0, 1'b0, len); check_eq("R8 single-cycle stall", len, 1);
        ovr_byte = -8'sd1;
        run_access(2'b10, 1'b0, 1'b1, 1'b0, len); check_eq("R7 bypass", len, 0);

        run_access(2'b00, 1'b0, 1'b0, 1'b1, len); check_eq("R9 stray strobe ignored", len, 17);
        repeat (4) @(negedge clk);
        check_eq("R9 no new access after stray", int'(stall), 0);

        repeat (3) @(posedge clk);
        finish_up();
    end

endmodule